// File: doc/BRIEF.md
# ECC Error Capture Log

This block keeps a record of the first single-bit or double-bit memory error reported by an ECC checker. When an error strobe arrives and the log is empty, the block latches who was using memory at that moment (the scrubber, the primary bus master or an alternate master), the level of the bus read pin, the error kind and the access address. It then sets a log-valid flag. While the flag is set, every captured field stays frozen and later errors are dropped.

Software reads the captured data through a small register bus. It acknowledges the entry by writing a one to the log-valid bit, which re-arms the block at once. Two instances are normally paired. A local acknowledge is driven out on `mirror_clr_out` so that the partner clears as well, and a clear arriving on `mirror_clr_in` acts like a local acknowledge. Software should read both logs before acknowledging.

Register map: offset 0 is the status byte. Its bit 0 is log valid, bit 1 the read pin, bit 2 scrubber source, bit 3 alternate master, bit 4 double-bit kind, and bits 7:5 read 0. Offset 1 holds address bits 31:24. Offsets 2 and 3 read 0. Read data is combinational from `reg_addr`.

Top module: `ecc_err_log`

## Requirements
- R1: With the log empty, a cycle with `err_single` or `err_double` high sets status bit 0 on the next clock edge.
- R2: While status bit 0 is set and no clear occurs, further error strobes change neither the status byte nor the address byte.
- R3: Status bit 0 is cleared only by a write to offset 0 with `reg_wdata[0]`=1 (or a mirrored clear). A write with bit 0 = 0, or a write to any other offset, leaves the status byte and the address byte unchanged. The bit is set only by capturing an error.
- R4: After a clear, an error in the very next cycle is captured.
- R5: Status bit 2 records `scrub_src` at capture (1 = scrubber).
- R6: Status bit 3 records 1 when `prim_master` was low at capture (an alternate master), and 0 otherwise.
- R7: Status bit 1 records the level of `bus_read` at capture. Its value has no meaning when bit 2 is set.
- R8: Offset 1 returns `bus_addr[31:24]` latched at capture.
- R9: A pulse on `mirror_clr_in` clears the log. `mirror_clr_out` is high in the same cycle as a local write-1 clear to offset 0, and low otherwise.
- R10: When a clear and an error strobe occur in the same cycle, the log ends valid and holds the new error's data.
- R11: Status bit 4 is 1 when `err_double` was high at capture, including when both strobes are high.
- R12: After reset, offsets 0 and 1 read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| err_single | input | 1 | Single-bit error strobe |
| err_double | input | 1 | Double-bit error strobe |
| scrub_src | input | 1 | Scrubber owns the current access |
| prim_master | input | 1 | High when the primary bus master owns the access |
| bus_read | input | 1 | Bus read pin level |
| bus_addr | input | 32 | Access address |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register offset |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data |
| mirror_clr_in | input | 1 | Clear from the paired instance |
| mirror_clr_out | output | 1 | Clear to the paired instance |

## Verification
The bench aims at the freeze window. A design that keeps capturing would overwrite the address byte with a later error's address. It also checks a write of zero to bit 0, which a design treating any write as an acknowledge would wrongly clear. The clear and error landing in the same cycle is driven directly: a design that gives the clear priority ends empty, and one that ignores the clear keeps stale data. Cases where both strobes fire at once, and mirrored clears in both directions, catch a kind bit that prefers single-bit errors and a partner link that is missing or always asserted.

// File: rtl/ecc_err_log.sv
module ecc_err_log #(
  parameter int ADDR_W  = 32,
  parameter int SLICE_W = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               err_single,
  input  logic               err_double,
  input  logic               scrub_src,
  input  logic               prim_master,
  input  logic               bus_read,
  input  logic [ADDR_W-1:0]  bus_addr,
  input  logic               reg_wr,
  input  logic [1:0]         reg_addr,
  input  logic [7:0]         reg_wdata,
  output logic [7:0]         reg_rdata,
  input  logic               mirror_clr_in,
  output logic               mirror_clr_out
);
  localparam int SLICE_LSB = ADDR_W - SLICE_W;

  logic              valid_q, rd_q, scr_q, alt_q, dbl_q;
  logic [ADDR_W-1:0] addr_q;
  logic              any_err, local_clr, clr, capture;
  logic [7:0]        status;

  assign any_err        = err_single | err_double;
  assign local_clr      = reg_wr && (reg_addr == 2'd0) && reg_wdata[0];
  assign clr            = local_clr | mirror_clr_in;
  assign capture        = any_err && (!valid_q || clr);
  assign mirror_clr_out = local_clr;
  assign status         = {3'b000, dbl_q, alt_q, scr_q, rd_q, valid_q};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      valid_q <= 1'b0;
      rd_q    <= 1'b0;
      scr_q   <= 1'b0;
      alt_q   <= 1'b0;
      dbl_q   <= 1'b0;
      addr_q  <= '0;
    end else if (capture) begin
      valid_q <= 1'b1;
      rd_q    <= bus_read;
      scr_q   <= scrub_src;
      alt_q   <= ~prim_master;
      dbl_q   <= err_double;
      addr_q  <= bus_addr;
    end else if (clr) begin
      valid_q <= 1'b0;
    end
  end

  always_comb begin
    case (reg_addr)
      2'd0:    reg_rdata = status;
      2'd1:    reg_rdata = addr_q[ADDR_W-1:SLICE_LSB];
      default: reg_rdata = 8'h00;
    endcase
  end

  assert_frozen_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_q && !clr) |=> (valid_q && $stable(status) && $stable(addr_q)));

  assert_set_by_error_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(valid_q) |-> $past(any_err));

  assert_clear_by_w1c_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(valid_q) |-> $past(reg_wr && reg_wdata[0] || mirror_clr_in));

  assert_clear_and_error_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (clr && any_err) |=> (valid_q && addr_q[ADDR_W-1:SLICE_LSB] == $past(bus_addr[ADDR_W-1:SLICE_LSB])));

  assert_double_kind_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (err_double && (!valid_q || clr)) |=> dbl_q);

  assert_empty_capture_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (!valid_q && any_err) |=> valid_q);
endmodule

// File: tb/ecc_err_log_test.sv
`timescale 1ns/1ps
module ecc_err_log_test;
  logic clk = 1'b0, rst_n = 1'b0;
  logic err_single = 0, err_double = 0, scrub_src = 0, prim_master = 1, bus_read = 0;
  logic [31:0] bus_addr = '0;
  logic reg_wr = 0;
  logic [1:0] reg_addr = 0;
  logic [7:0] reg_wdata = 0;
  logic [7:0] reg_rdata;
  logic mirror_clr_in = 0, mirror_clr_out;

  int checks = 0, fails = 0;
  bit done = 0;

  logic m_valid = 0, m_rd = 0, m_scr = 0, m_alt = 0, m_dbl = 0;
  logic [31:0] m_addr = '0;

  always #5 clk = ~clk;

  ecc_err_log uut (
    .clk(clk), .rst_n(rst_n), .err_single(err_single), .err_double(err_double),
    .scrub_src(scrub_src), .prim_master(prim_master), .bus_read(bus_read),
    .bus_addr(bus_addr), .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .mirror_clr_in(mirror_clr_in), .mirror_clr_out(mirror_clr_out)
  );

  function automatic logic [7:0] exp_status();
    return {3'b000, m_dbl, m_alt, m_scr, m_rd, m_valid};
  endfunction

  function automatic logic exp_local_clr(logic wr, logic [1:0] wa, logic [7:0] wd);
    return wr && (wa == 2'd0) && wd[0];
  endfunction

  task automatic check(string tag, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %02h expected %02h", tag, act, exp);
    end
  endtask

  task automatic check_regs(string tag);
    reg_wr = 0;
    reg_addr = 2'd0; #1;
    check({tag, " status"}, reg_rdata, exp_status());
    reg_addr = 2'd1; #1;
    check({tag, " addr"}, reg_rdata, m_addr[31:24]);
  endtask

  task automatic step(string tag, logic es, logic ed, logic scr, logic prim, logic rd,
                      logic [31:0] a, logic wr, logic [1:0] wa, logic [7:0] wd, logic mc);
    logic clr, lc;
    err_single = es; err_double = ed; scrub_src = scr; prim_master = prim;
    bus_read = rd; bus_addr = a; reg_wr = wr; reg_addr = wa; reg_wdata = wd;
    mirror_clr_in = mc;
    lc  = exp_local_clr(wr, wa, wd);
    clr = lc || mc;
    #1;
    check({tag, " R9 mirror_out"}, {7'b0, mirror_clr_out}, {7'b0, lc});
    if ((es || ed) && (!m_valid || clr)) begin
      m_valid = 1; m_rd = rd; m_scr = scr; m_alt = ~prim; m_dbl = ed; m_addr = a;
    end else if (clr) m_valid = 0;
    @(posedge clk); @(negedge clk);
    err_single = 0; err_double = 0; reg_wr = 0; mirror_clr_in = 0;
    check_regs(tag);
  endtask

  task automatic idle(string tag);
    step(tag, 0, 0, 0, 1, 0, 32'h0, 0, 0, 0, 0);
  endtask

  initial begin
    #(200000 * 10);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    int unsigned seed;
    repeat (3) @(negedge clk);
    rst_n = 1;
    check_regs("R12 reset");
    idle("R12 idle");

    step("R1 R5 R6 R7 R8 single", 1, 0, 0, 1, 1, 32'hA5123456, 0, 0, 0, 0);
    step("R2 later error ignored", 0, 1, 1, 0, 0, 32'h3C000000, 0, 0, 0, 0);
    step("R3 write0 no effect", 0, 0, 0, 1, 0, 0, 1, 2'd0, 8'hFE, 0);
    step("R3 write other offset", 0, 0, 0, 1, 0, 0, 1, 2'd1, 8'hFF, 0);
    step("R3 clear", 0, 0, 0, 1, 0, 0, 1, 2'd0, 8'h01, 0);
    step("R4 R5 R6 R11 rearm scrub", 0, 1, 1, 1, 0, 32'h7E00FF00, 0, 0, 0, 0);
    step("R10 clear+error", 1, 0, 0, 0, 1, 32'hC3000001, 1, 2'd0, 8'h01, 0);
    step("R9 mirror in", 0, 0, 0, 1, 0, 0, 0, 0, 0, 1);
    step("R11 both strobes", 1, 1, 0, 0, 1, 32'h19000000, 0, 0, 0, 0);
    step("R10 R9 mirror+error", 1, 0, 1, 1, 0, 32'hF0F0F0F0, 0, 0, 0, 1);

    seed = $urandom(32'h5EED1234);
    for (int i = 0; i < 400; i++) begin
      logic es, ed, wr, mc;
      es = ($urandom % 6) == 0;
      ed = ($urandom % 8) == 0;
      wr = ($urandom % 5) == 0;
      mc = ($urandom % 12) == 0;
      step("R1 R2 R3 R10 R11 random", es, ed, 1'($urandom), 1'($urandom), 1'($urandom),
           $urandom, wr, 2'($urandom), 8'($urandom), mc);
    end

    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule